// File: doc/BRIEF.md
# Prescaled Presettable Base Timer

An 8-bit up-counter for a small microcontroller register bus. The counter advances once per prescaled period. The period is the system clock divided by a power of two, chosen by a 3-bit select field. Software can load a new count at any moment. Counting is gated by a run-control bit that is active low, so the timer is stopped after reset. When an advance takes the count to its all-ones value, the block emits a one-clock overflow request toward an interrupt flag kept elsewhere. The count then wraps to zero and keeps going.

The CPU reaches the block through a single-cycle write strobe, a 2-bit register select and a combinational read path. Firmware normally programs the divider first, then loads the count, then clears the halt bit.

Top module: `base_tick_timer`

## Requirements
- R1: After reset the count reads 00h, the control register reads 01h (halted), the mode register reads 00h, and the overflow output is low.
- R2: Register select 0 is the 8-bit count (read/write). Select 1 is control, where bit 0 is the halt bit (1 = stopped, 0 = running) and the other bits read 0. Select 2 is mode, where bits [2:0] are the divider select and the other bits read 0. Select 3 reads 00h, and writes to it change nothing.
- R3: While running, the count increments exactly once every 2^(3+sel) clocks, for every sel from 0 (divide by 8) to 7 (divide by 1024).
- R4: The halt bit acts as a level. While it is 1 the count holds. Writing 0 to an already running timer does not disturb the prescaler phase.
- R5: A write to the count takes effect on the next clock and restarts the prescaler phase, so the next increment comes a full period later. Enabling the timer also starts from a fresh phase.
- R6: The overflow output is a single-clock pulse. It is high in the first cycle in which the count reads FFh after an increment from FEh. From the write that enables the timer with preset P and select sel, it rises after 2^(3+sel)·(255−P) clocks.
- R7: One period after the count reaches FFh, it wraps to 00h and counting continues.
- R8: Loading FFh directly raises no overflow. The next overflow comes 256 increments later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released in step with clk_i |
| wr_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| ovf_o | output | 1 | One-clock overflow request |

## Verification
Every divider code, including the top code, is paired with a different preset, so the overflow latency tells a wrong divider apart from a wrong count distance. A preset written into a running timer separates a prescaler that restarts from one that keeps its old phase. A redundant write of 0 to the halt bit separates level behaviour from edge behaviour. Held-count windows while halted, and a direct load of FFh, check that counting and overflow come only from real increments.

// File: rtl/btmr_pkg.sv
package btmr_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_MODE  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/btmr_regs.sv
module btmr_regs
  import btmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit0_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [DATA_W-1:0] count_i,
  output logic              halt_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              count_wr_o,
  output logic              run_toggle_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_CTRL = DATA_W - 1;
  localparam int unsigned PAD_MODE = DATA_W - SEL_W;

  logic             halt_q, halt_d, halt_en;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;
  reg_sel_e         addr_s;

  assign addr_s = reg_sel_e'(addr_i);

  // next-state decode
  always_comb begin
    halt_en = wr_i && (addr_s == REG_CTRL);
    sel_en  = wr_i && (addr_s == REG_MODE);
    halt_d  = wbit0_i;
    sel_d   = wsel_i;
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b1;
      sel_q  <= '0;
    end else begin
      if (halt_en) halt_q <= halt_d;
      if (sel_en)  sel_q  <= sel_d;
    end
  end

  assign count_wr_o   = wr_i && (addr_s == REG_COUNT);
  assign run_toggle_o = halt_en && (halt_d != halt_q);
  assign halt_o       = halt_q;
  assign sel_o        = sel_q;

  // read path
  always_comb begin
    unique case (addr_s)
      REG_COUNT: rdata_o = count_i;
      REG_CTRL:  rdata_o = {{PAD_CTRL{1'b0}}, halt_q};
      REG_MODE:  rdata_o = {{PAD_MODE{1'b0}}, sel_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/btmr_prescaler.sv
module btmr_prescaler #(
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned BASE_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NUM_SEL = 1 << SEL_W;
  localparam int unsigned PRE_W   = BASE_SHIFT + NUM_SEL - 1;

  logic [PRE_W-1:0] last_tbl [NUM_SEL];
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;
  logic             at_last;

  // terminal value per divider code: 2^(BASE_SHIFT+code) - 1
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_last
    localparam int unsigned LASTV = (1 << (BASE_SHIFT + g)) - 1;
    assign last_tbl[g] = PRE_W'(LASTV);
  end

  assign at_last = (pre_q == last_tbl[sel_i]);
  assign tick_o  = run_i && !restart_i && at_last;

  // next-state
  always_comb begin
    pre_en = 1'b1;
    if (!run_i || restart_i || at_last) pre_d = '0;
    else                                pre_d = pre_q + PRE_W'(1);
    if (!run_i && (pre_q == '0)) pre_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/btmr_counter.sv
module btmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] PRE_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_en = load_i || tick_i;
    cnt_d  = load_i ? load_val_i : cnt_q + CNT_W'(1);
    ovf_d  = tick_i && !load_i && (cnt_q == PRE_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/base_tick_timer.sv
module base_tick_timer
  import btmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned BASE_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              ovf_o
);
  logic             halt;
  logic [SEL_W-1:0] sel;
  logic             count_wr;
  logic             run_toggle;
  logic             tick;
  logic [CNT_W-1:0] count;

  btmr_regs #(.DATA_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wbit0_i     (wdata_i[0]),
    .wsel_i      (wdata_i[SEL_W-1:0]),
    .count_i     (count),
    .halt_o      (halt),
    .sel_o       (sel),
    .count_wr_o  (count_wr),
    .run_toggle_o(run_toggle),
    .rdata_o     (rdata_o)
  );

  btmr_prescaler #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (!halt),
    .restart_i(count_wr || run_toggle),
    .sel_i    (sel),
    .tick_o   (tick)
  );

  btmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (count_wr),
    .load_val_i(wdata_i),
    .count_o   (count),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/btmr_chk.sv
module btmr_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovf_o,
  input logic [CNT_W-1:0] count,
  input logic             halt,
  input logic             count_wr,
  input logic [CNT_W-1:0] wdata_i
);
  // R6
  ovf_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  // R6
  ovf_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count == {CNT_W{1'b1}}));

  // R4
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !count_wr) |=> $stable(count));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt && !count_wr) |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));

  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_wr |=> (count == $past(wdata_i)));

  // R8
  halted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && $past(halt)) |-> !ovf_o);
endmodule

bind base_tick_timer btmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ovf_o   (ovf_o),
  .count   (count),
  .halt    (halt),
  .count_wr(count_wr),
  .wdata_i (wdata_i)
);

// File: tb/base_tick_timer_tb.sv
`timescale 1ns/1ps
module base_tick_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       ovf_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  base_tick_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ovf_o(ovf_o)
  );

  // {sel[10:8], preset[7:0]}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'hF0}, {3'd1, 8'h80}, {3'd2, 8'hFD}, {3'd3, 8'h10},
    {3'd4, 8'hFA}, {3'd5, 8'hF8}, {3'd6, 8'hFE}, {3'd7, 8'hFC}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
    addr_i = 2'd0;
  endtask

  task automatic wait_ovf(output int at);
    for (int i = 0; i < 20000 && !ovf_o; i++) @(negedge clk_i);
    at = cyc;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int t0, at, n;
    rst_ni = 1'b0; wr_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 8'h00);
    rd(2'd1, v); check("R1 control", v, 8'h01);
    rd(2'd2, v); check("R1 mode", v, 8'h00);
    check("R1 ovf", ovf_o, 0);

    // R2 field widths and spare select
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R2 mode mask", v, 8'h07);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R2 control mask", v, 8'h01);
    wr(2'd3, 8'h55); rd(2'd3, v); check("R2 spare read", v, 8'h00);
    rd(2'd0, v); check("R2 spare write ignored", v, 8'h00);
    rd(2'd2, v); check("R2 spare write leaves mode", v, 8'h07);

    // R3 R6 R7: one vector per divider code
    for (int k = 0; k < 8; k++) begin
      int sel, p;
      sel = int'(VEC[k][10:8]);
      p   = int'(VEC[k][7:0]);
      n   = 1 << (3 + sel);
      wr(2'd2, 8'(sel));
      wr(2'd0, 8'(p));
      rd(2'd0, v); check("R5 preset readback", v, p);
      wr(2'd1, 8'h00);
      t0 = cyc;
      wait_ovf(at);
      check($sformatf("R6 latency sel=%0d (R3 divider)", sel), at - t0, n * (255 - p));
      rd(2'd0, v); check("R6 count at pulse", v, 8'hFF);
      @(negedge clk_i);
      check("R6 single pulse", ovf_o, 0);
      repeat (n - 1) @(negedge clk_i);
      rd(2'd0, v); check("R7 wrap to zero", v, 8'h00);
      wr(2'd1, 8'h01);
    end

    // R4 halted timer holds, then runs, then holds again
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h10);
    repeat (100) @(negedge clk_i);
    rd(2'd0, v); check("R4 hold while halted", v, 8'h10);
    wr(2'd1, 8'h00);
    t0 = cyc;
    while (cyc < t0 + 24) @(negedge clk_i);
    rd(2'd0, v); check("R3 three periods of 8", v, 8'h13);
    wr(2'd1, 8'h01);
    repeat (50) @(negedge clk_i);
    rd(2'd0, v); check("R4 hold after halt", v, 8'h13);

    // R4 level: redundant run write does not shift the phase
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hF8);
    wr(2'd1, 8'h00);
    t0 = cyc;
    repeat (5) @(negedge clk_i);
    wr(2'd1, 8'h00);
    wait_ovf(at);
    check("R4 level enable latency", at - t0, 16 * 7);
    wr(2'd1, 8'h01);

    // R5 preset while running restarts the phase
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    repeat (13) @(negedge clk_i);
    wr(2'd0, 8'hF0);
    t0 = cyc;
    wait_ovf(at);
    check("R5 running preset latency", at - t0, 8 * 15);
    wr(2'd1, 8'h01);

    // R8 direct load of FFh
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    t0 = cyc;
    repeat (4) @(negedge clk_i);
    check("R8 no pulse on load", ovf_o, 0);
    wait_ovf(at);
    check("R8 full-wrap latency", at - t0, 8 * 256);
    wr(2'd1, 8'h01);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule